// File: doc/BRIEF.md
# Tamper Detect and Record Unit

This block supervises three tamper indications from on-chip sensors: clock, temperature and supply voltage. Each indication feeds two independent detector banks, a primary bank and an auxiliary bank. Each bank gates every indication by its own enable bit and keeps a sticky record bit. A record bit stays set until software writes a one to it. The auxiliary bank also has a global switch and a trim register. The trim register drives calibration fields towards the analog sensors.

A power-glitch monitor holds a 32-bit check word. Its record bit is set on every cycle in which the word differs from a fixed magic value. This includes the time after reset, when the word is zero. Software writes the magic value and then clears the record. If the check word is later corrupted, the record sets again.

Any set record in either bank, or a set glitch record, raises a single violation output. That output is meant for the chip's security state monitor.

Software reaches the registers through a simple single-cycle port. A bank-select input chooses between the primary register space and the auxiliary register space. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `tamper_supervisor`

## Requirements
- R1: While `rst` is high, and at the first edge after it, all enable, record, check-word and trim registers hold zero. Every register reads 0, the trim outputs are 0 and `violation` is low.
- R2: Primary enable register, main space offset 0x48: bit 6 enables voltage, bit 5 temperature, bit 4 clock. An asserted sensor sets its record at the next edge only when its enable bit is 1. A sensor whose enable is 0 leaves the record unchanged.
- R3: A set record stays set after the sensor input drops, for as long as it is not cleared.
- R4: Primary status register, main space offset 0x4C: bit 6 records voltage, bit 5 temperature, bit 4 clock. Writing 1 to a record bit clears it and writing 0 leaves it. When a detection and a clear happen in the same cycle, the detection wins and the bit stays 1.
- R5: Check word, main space offset 0x64, is a 32-bit read/write register. Status bit 3 is the glitch record. It is set at every edge where the word differs from 0x41736166, including just after reset. It clears on a 1 written to bit 3 only while the word matches.
- R6: Auxiliary global enable, aux space offset 0x00 bit 0. Auxiliary detect enables, aux space offset 0x0C: bit 2 clock, bit 1 voltage, bit 0 temperature. An auxiliary record sets only when both the global enable and its detect bit are 1.
- R7: Auxiliary records, aux space offset 0x08: bit 2 clock, bit 1 temperature, bit 0 voltage. They are sticky and write-one-to-clear, and a detection wins over a same-cycle clear.
- R8: Trim register, aux space offset 0x04, is fully read/write. It drives the temperature trim from bits 31:22, the voltage trim from bits 21:12, the bandgap trim from bits 11:6 and the program trim from bits 5:0.
- R9: `violation` is high exactly when any primary record, any auxiliary record or the glitch record is set.
- R10: Unmapped offsets in either space read 0 and ignore writes. Bits outside the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_aux | input | 1 | Register space select: 0 primary, 1 auxiliary |
| reg_addr | input | ADDR_W | Byte offset within the selected space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| sense_clk | input | 1 | Clock tamper indication |
| sense_temp | input | 1 | Temperature tamper indication |
| sense_volt | input | 1 | Voltage tamper indication |
| trim_temp | output | 10 | Temperature trim field |
| trim_volt | output | 10 | Voltage trim field |
| trim_bgap | output | 6 | Bandgap trim field |
| trim_prog | output | 6 | Program trim field |
| violation | output | 1 | OR of all record bits |

## Verification
Some behaviours are checked on every cycle by the embedded properties:
- a record never drops without a clear;
- an enabled hit always sets its record;
- a clear without a hit always drops it;
- a mismatching check word always raises the glitch record;
- an idle bank with no enables never acquires a record.

The directed scenarios cover what those properties cannot see:
- the exact bit positions at both register spaces, including the swapped voltage/temperature order between the auxiliary enable and record registers;
- the trim field slicing;
- the reads of unmapped offsets;
- the sequence of writing the magic word before clearing the glitch record.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

    localparam int REG_W = 32;
    localparam int NCH   = 3;

    // primary space offsets
    localparam logic [7:0] OFS_MAIN_EN     = 8'h48;
    localparam logic [7:0] OFS_MAIN_STAT   = 8'h4C;
    localparam logic [7:0] OFS_MAIN_GLITCH = 8'h64;
    // auxiliary space offsets
    localparam logic [7:0] OFS_AUX_CTRL    = 8'h00;
    localparam logic [7:0] OFS_AUX_TRIM    = 8'h04;
    localparam logic [7:0] OFS_AUX_REC     = 8'h08;
    localparam logic [7:0] OFS_AUX_DET     = 8'h0C;

    // primary enable/record field: bits 6:4
    localparam int MAIN_LSB   = 4;
    localparam int GLITCH_BIT = 3;

    typedef struct packed {
        logic clk_t;
        logic temp;
        logic volt;
    } sense_t;

    typedef struct packed {
        logic [9:0] temp;
        logic [9:0] volt;
        logic [5:0] bgap;
        logic [5:0] prog;
    } trim_t;

    // primary bank internal order: [2]=volt [1]=temp [0]=clk
    function automatic logic [NCH-1:0] main_hits(sense_t s);
        return {s.volt, s.temp, s.clk_t};
    endfunction

    // auxiliary record order: [2]=clk [1]=temp [0]=volt
    function automatic logic [NCH-1:0] aux_hits(sense_t s);
        return {s.clk_t, s.temp, s.volt};
    endfunction

    // auxiliary detect register: [2]=clk [1]=volt [0]=temp -> record order
    function automatic logic [NCH-1:0] aux_det_to_rec(logic [NCH-1:0] d);
        return {d[2], d[0], d[1]};
    endfunction

endpackage

// File: rtl/tamper_rec_bank.sv
module tamper_rec_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    output logic [N-1:0] rec
);

    logic [N-1:0] rec_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    rec_q[i] <= 1'b0;
                end else if (en[i] && hit[i]) begin
                    rec_q[i] <= 1'b1;
                end else if (clr[i]) begin
                    rec_q[i] <= 1'b0;
                end
            end

            assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
                rec_q[i] && !clr[i] |=> rec_q[i]);

            assert_hit_wins_R4: assert property (@(posedge clk) disable iff (rst)
                en[i] && hit[i] |=> rec_q[i]);

            assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
                clr[i] && !(en[i] && hit[i]) |=> !rec_q[i]);

            assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
                !rec_q[i] && !(en[i] && hit[i]) |=> !rec_q[i]);
        end
    endgenerate

    assign rec = rec_q;

endmodule

// File: rtl/tamper_glitch_mon.sv
module tamper_glitch_mon #(
    parameter int          W     = 32,
    parameter logic [W-1:0] MAGIC = 32'h41736166
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_we,
    input  logic [W-1:0] word_wdata,
    input  logic         clr,
    output logic [W-1:0] word,
    output logic         rec
);

    logic [W-1:0] word_q;
    logic         rec_q;
    logic         mismatch;

    assign mismatch = (word_q != MAGIC);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (word_we) begin
            word_q <= word_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= 1'b0;
        end else if (mismatch) begin
            rec_q <= 1'b1;
        end else if (clr) begin
            rec_q <= 1'b0;
        end
    end

    assert_mismatch_sets_R5: assert property (@(posedge clk) disable iff (rst)
        word_q != MAGIC |=> rec_q);

    assert_glitch_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        rec_q && !clr |=> rec_q);

    assign word = word_q;
    assign rec  = rec_q;

endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
    import tamper_pkg::*;
#(
    parameter int               ADDR_W       = 8,
    parameter logic [REG_W-1:0] GLITCH_MAGIC = 32'h41736166
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_aux,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sense_clk,
    input  logic              sense_temp,
    input  logic              sense_volt,
    output logic [9:0]        trim_temp,
    output logic [9:0]        trim_volt,
    output logic [5:0]        trim_bgap,
    output logic [5:0]        trim_prog,
    output logic              violation
);

    localparam int MAIN_MSB = MAIN_LSB + NCH - 1;

    function automatic logic hit_ofs(logic [ADDR_W-1:0] a, logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    sense_t sense;
    assign sense = '{clk_t: sense_clk, temp: sense_temp, volt: sense_volt};

    // decode
    logic sel_main_en, sel_main_stat, sel_main_glitch;
    logic sel_aux_ctrl, sel_aux_trim, sel_aux_rec, sel_aux_det;

    always_comb begin
        sel_main_en     = !reg_aux && hit_ofs(reg_addr, OFS_MAIN_EN);
        sel_main_stat   = !reg_aux && hit_ofs(reg_addr, OFS_MAIN_STAT);
        sel_main_glitch = !reg_aux && hit_ofs(reg_addr, OFS_MAIN_GLITCH);
        sel_aux_ctrl    =  reg_aux && hit_ofs(reg_addr, OFS_AUX_CTRL);
        sel_aux_trim    =  reg_aux && hit_ofs(reg_addr, OFS_AUX_TRIM);
        sel_aux_rec     =  reg_aux && hit_ofs(reg_addr, OFS_AUX_REC);
        sel_aux_det     =  reg_aux && hit_ofs(reg_addr, OFS_AUX_DET);
    end

    // configuration registers
    logic [NCH-1:0] main_en_q;
    logic           aux_on_q;
    logic [NCH-1:0] aux_det_q;
    trim_t          trim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_en_q <= '0;
            aux_on_q  <= 1'b0;
            aux_det_q <= '0;
            trim_q    <= '0;
        end else if (reg_we) begin
            if (sel_main_en)  main_en_q <= reg_wdata[MAIN_MSB:MAIN_LSB];
            if (sel_aux_ctrl) aux_on_q  <= reg_wdata[0];
            if (sel_aux_det)  aux_det_q <= reg_wdata[NCH-1:0];
            if (sel_aux_trim) trim_q    <= trim_t'(reg_wdata);
        end
    end

    // primary bank
    logic [NCH-1:0] main_clr, main_rec;
    assign main_clr = (reg_we && sel_main_stat) ? reg_wdata[MAIN_MSB:MAIN_LSB] : '0;

    tamper_rec_bank #(.N(NCH)) u_main_bank (
        .clk (clk),
        .rst (rst),
        .en  (main_en_q),
        .hit (main_hits(sense)),
        .clr (main_clr),
        .rec (main_rec)
    );

    // auxiliary bank
    logic [NCH-1:0] aux_en, aux_clr, aux_rec;
    assign aux_en  = {NCH{aux_on_q}} & aux_det_to_rec(aux_det_q);
    assign aux_clr = (reg_we && sel_aux_rec) ? reg_wdata[NCH-1:0] : '0;

    tamper_rec_bank #(.N(NCH)) u_aux_bank (
        .clk (clk),
        .rst (rst),
        .en  (aux_en),
        .hit (aux_hits(sense)),
        .clr (aux_clr),
        .rec (aux_rec)
    );

    // glitch monitor
    logic [REG_W-1:0] glitch_word;
    logic             glitch_rec;

    tamper_glitch_mon #(.W(REG_W), .MAGIC(GLITCH_MAGIC)) u_glitch (
        .clk        (clk),
        .rst        (rst),
        .word_we    (reg_we && sel_main_glitch),
        .word_wdata (reg_wdata),
        .clr        (reg_we && sel_main_stat && reg_wdata[GLITCH_BIT]),
        .word       (glitch_word),
        .rec        (glitch_rec)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            sel_main_en:     reg_rdata[MAIN_MSB:MAIN_LSB] = main_en_q;
            sel_main_stat: begin
                reg_rdata[MAIN_MSB:MAIN_LSB] = main_rec;
                reg_rdata[GLITCH_BIT]        = glitch_rec;
            end
            sel_main_glitch: reg_rdata = glitch_word;
            sel_aux_ctrl:    reg_rdata[0] = aux_on_q;
            sel_aux_trim:    reg_rdata = REG_W'(trim_q);
            sel_aux_rec:     reg_rdata[NCH-1:0] = aux_rec;
            sel_aux_det:     reg_rdata[NCH-1:0] = aux_det_q;
            default:         reg_rdata = '0;
        endcase
    end

    assign trim_temp = trim_q.temp;
    assign trim_volt = trim_q.volt;
    assign trim_bgap = trim_q.bgap;
    assign trim_prog = trim_q.prog;

    assign violation = glitch_rec | (|main_rec) | (|aux_rec);

    assert_aux_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !aux_on_q && aux_rec == '0 |=> aux_rec == '0);

    assert_main_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        main_en_q == '0 && main_rec == '0 |=> main_rec == '0);

    assert_trim_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && sel_aux_trim) |=> $stable({trim_temp, trim_volt, trim_bgap, trim_prog}));

endmodule

// File: tb/tamper_supervisor_test.sv
module tamper_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAGIC = 32'h41736166;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_aux = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sense_clk = 1'b0, sense_temp = 1'b0, sense_volt = 1'b0;
    logic [9:0]  trim_temp, trim_volt;
    logic [5:0]  trim_bgap, trim_prog;
    logic        violation;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tamper_supervisor uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_aux(reg_aux),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sense_clk(sense_clk), .sense_temp(sense_temp), .sense_volt(sense_volt),
        .trim_temp(trim_temp), .trim_volt(trim_volt), .trim_bgap(trim_bgap),
        .trim_prog(trim_prog), .violation(violation)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(bit aux, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_aux = aux; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(bit aux, logic [7:0] a, output logic [31:0] d);
        reg_aux = aux; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(bit c, bit t, bit v);
        @(negedge clk);
        sense_clk = c; sense_temp = t; sense_volt = v;
        @(negedge clk);
        sense_clk = 0; sense_temp = 0; sense_volt = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rd(0, 8'h48, d); chk("R1 main enable", d, 0);
        rd(0, 8'h4C, d); chk("R1 main status", d, 0);
        rd(0, 8'h64, d); chk("R1 check word", d, 0);
        rd(1, 8'h04, d); chk("R1 trim", d, 0);
        rd(1, 8'h08, d); chk("R1 aux records", d, 0);
        chk("R1 trim outputs", {trim_temp, trim_volt, trim_bgap, trim_prog}, 0);
        chk("R1 violation", violation, 0);
        rst = 1'b0;
    endtask

    task automatic t_glitch_init();
        logic [31:0] d;
        @(negedge clk);
        rd(0, 8'h4C, d); chk("R5 glitch set after reset", d, 32'h8);
        chk("R9 violation from glitch", violation, 1);
        wr(0, 8'h64, MAGIC);
        rd(0, 8'h64, d); chk("R5 check word readback", d, MAGIC);
        rd(0, 8'h4C, d); chk("R5 record sticky until cleared", d, 32'h8);
        wr(0, 8'h4C, 32'h8);
        rd(0, 8'h4C, d); chk("R5 glitch cleared", d, 0);
        chk("R9 violation low", violation, 0);
    endtask

    task automatic t_main_detect();
        logic [31:0] d;
        pulse(1, 1, 1);
        rd(0, 8'h4C, d); chk("R2 disabled sensors ignored", d, 0);
        wr(0, 8'h48, 32'h70);
        pulse(0, 1, 0);
        rd(0, 8'h4C, d); chk("R2 temp at bit5", d, 32'h20);
        repeat (3) @(negedge clk);
        rd(0, 8'h4C, d); chk("R3 sticky after drop", d, 32'h20);
        chk("R9 violation from main", violation, 1);
        pulse(1, 0, 0);
        rd(0, 8'h4C, d); chk("R2 clk at bit4", d, 32'h30);
        pulse(0, 0, 1);
        rd(0, 8'h4C, d); chk("R2 volt at bit6", d, 32'h70);
        wr(0, 8'h4C, 32'h0);
        rd(0, 8'h4C, d); chk("R4 write zero keeps", d, 32'h70);
        wr(0, 8'h4C, 32'h20);
        rd(0, 8'h4C, d); chk("R4 clear one bit", d, 32'h50);
        wr(0, 8'h4C, 32'h50);
        rd(0, 8'h4C, d); chk("R4 clear rest", d, 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        @(negedge clk); sense_clk = 1;
        @(negedge clk);
        reg_we = 1; reg_aux = 0; reg_addr = 8'h4C; reg_wdata = 32'h10;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0; sense_clk = 0;
        rd(0, 8'h4C, d); chk("R4 detect wins over clear", d, 32'h10);
        wr(0, 8'h4C, 32'h10);
        rd(0, 8'h4C, d); chk("R4 cleared after sensor low", d, 0);
        wr(0, 8'h48, 32'h0);
    endtask

    task automatic t_glitch_corrupt();
        logic [31:0] d;
        wr(0, 8'h64, 32'h12345678);
        @(negedge clk);
        rd(0, 8'h4C, d); chk("R5 mismatch sets record", d, 32'h8);
        wr(0, 8'h4C, 32'h8);
        rd(0, 8'h4C, d); chk("R5 no clear while mismatched", d, 32'h8);
        wr(0, 8'h64, MAGIC);
        wr(0, 8'h4C, 32'h8);
        rd(0, 8'h4C, d); chk("R5 clear after restore", d, 0);
    endtask

    task automatic t_aux();
        logic [31:0] d;
        wr(1, 8'h0C, 32'h7);
        pulse(1, 1, 1);
        rd(1, 8'h08, d); chk("R6 global off ignores", d, 0);
        rd(0, 8'h4C, d); chk("R2 main disabled stays clear", d, 0);
        wr(1, 8'h00, 32'h1);
        rd(1, 8'h00, d); chk("R6 global enable readback", d, 1);
        wr(1, 8'h0C, 32'h2);
        pulse(0, 0, 1);
        rd(1, 8'h08, d); chk("R7 volt record at bit0", d, 32'h1);
        pulse(0, 1, 0);
        rd(1, 8'h08, d); chk("R6 temp detect off ignores", d, 32'h1);
        wr(1, 8'h0C, 32'h5);
        pulse(0, 1, 0);
        rd(1, 8'h08, d); chk("R7 temp record at bit1", d, 32'h3);
        pulse(1, 0, 0);
        rd(1, 8'h08, d); chk("R7 clk record at bit2", d, 32'h7);
        chk("R9 violation from aux", violation, 1);
        wr(1, 8'h08, 32'h6);
        rd(1, 8'h08, d); chk("R7 partial clear", d, 32'h1);
        wr(1, 8'h08, 32'h1);
        rd(1, 8'h08, d); chk("R7 full clear", d, 0);
        chk("R9 violation low again", violation, 0);
    endtask

    task automatic t_trim();
        logic [31:0] d;
        logic [31:0] v = 32'hDEADBEEF;
        wr(1, 8'h04, v);
        rd(1, 8'h04, d); chk("R8 trim readback", d, v);
        chk("R8 temp trim", trim_temp, (v >> 22) & 32'h3FF);
        chk("R8 volt trim", trim_volt, (v >> 12) & 32'h3FF);
        chk("R8 bandgap trim", trim_bgap, (v >> 6) & 32'h3F);
        chk("R8 program trim", trim_prog, v & 32'h3F);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(1, 8'h10, 32'hFFFFFFFF);
        rd(1, 8'h10, d); chk("R10 aux unmapped", d, 0);
        rd(0, 8'h04, d); chk("R10 main space at trim offset", d, 0);
        wr(0, 8'h48, 32'hFFFFFFFF);
        rd(0, 8'h48, d); chk("R10 main enable reserved bits", d, 32'h70);
        wr(0, 8'h48, 32'h0);
        wr(1, 8'h00, 32'hFFFFFFFE);
        rd(1, 8'h00, d); chk("R10 aux ctrl reserved bits", d, 0);
        wr(1, 8'h0C, 32'hFFFFFFFF);
        rd(1, 8'h0C, d); chk("R10 aux detect reserved bits", d, 32'h7);
        rd(1, 8'h04, d); chk("R10 trim untouched", d, 32'hDEADBEEF);
    endtask

    initial begin
        t_reset();
        t_glitch_init();
        t_main_detect();
        t_priority();
        t_glitch_corrupt();
        t_aux();
        t_trim();
        t_unmapped();
        @(negedge clk);
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule